// File: doc/BRIEF.md
# Cascade Match-Flag Stage

This block is the per-device piece of a vertical cascade of content-addressable memories. Each device in the cascade takes the active-low match indication of the device above it (higher priority), merges it with its own search result, and drives an active-low match indication to the device below it. The flag at the bottom of the cascade is the system-wide "something matched" signal. Each device also works out whether it holds the highest-priority match, so that only that device answers a follow-on read of associated data.

Device accesses are framed by an active-low strobe, sampled on the system clock. The chain-enable input is captured when the strobe is seen going low; the local search result and the match-flag enable are captured when the strobe is seen going high. From that point, until the next strobe rise, the outgoing flag and the owner indication follow the captured state combined with the live incoming flag, so a priority decision ripples down the cascade with no clock per stage. A pulse that announces a switch of the active configuration set clears the outgoing flag at once.

Top module: `chain_match_flag`

## Requirements
- R1: After reset `match_out_n` is 1 and `owner` is 0 until the first strobe rise that finds the chain enabled.
- R2: A strobe rise is a clock edge at which `strobe_n` is sampled 1 after being sampled 0 at the edge before; a fall is the reverse. At a rise, the block captures `local_hit & flag_en`; if the chain is enabled, `match_out_n` then equals NOT(captured flag OR NOT `match_in_n`), following `match_in_n` without a clock.
- R3: If the chain is enabled and `flag_en` was 0 at the rise, `match_out_n` equals `match_in_n`.
- R4: The chain is enabled for a strobe cycle only when `chain_en_n` is 0 at that cycle's fall; otherwise after the rise `match_out_n` is 1 and `owner` is 0 whatever the other inputs.
- R5: Changes of `local_hit` or `flag_en` at any edge other than a rise do not change `match_out_n` or `owner`.
- R6: Changes of `chain_en_n` after the fall has been sampled do not affect that strobe cycle.
- R7: `cfg_swap` sampled 1 at an edge sets `match_out_n` to 1 and `owner` to 0 from that edge, taking priority over a rise at the same edge, until the next rise.
- R8: `owner` is 1 exactly when the chain is enabled, the captured flag is 1 and `match_in_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low access strobe |
| chain_en_n | input | 1 | Active-low chain enable, captured at strobe fall |
| local_hit | input | 1 | This device has one or more valid matches |
| match_in_n | input | 1 | Active-low match flag from higher-priority device |
| flag_en | input | 1 | Match-flag enable bit from the control register |
| cfg_swap | input | 1 | Pulse: active configuration set switched |
| match_out_n | output | 1 | Active-low match flag to lower-priority device |
| owner | output | 1 | This device holds the highest-priority match |

## Verification
The chain enable takes effect one edge after the strobe is driven low and the captured flag one edge after it is driven high, so the bench drives at the falling clock edge and samples at the next falling edge after the edge that sees the transition. A `cfg_swap` pulse is due at the edge that samples it. Changes of `match_in_n` reach `match_out_n` with no clock, so those checks sample one nanosecond after the change. All sixteen combinations of chain enable, flag enable, local hit and incoming flag are swept, each with mid-cycle disturbances of the ignored inputs checked before the next rise.

// File: rtl/chain_match_flag.sv
module chain_match_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic chain_en_n,
  input  logic local_hit,
  input  logic match_in_n,
  input  logic flag_en,
  input  logic cfg_swap,
  output logic match_out_n,
  output logic owner
);

  logic strobe_q;
  logic armed;
  logic out_en;
  logic hit_q;

  wire strobe_fall = strobe_q & ~strobe_n;
  wire strobe_rise = ~strobe_q & strobe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      armed    <= 1'b0;
      out_en   <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      if (strobe_fall)
        armed <= ~chain_en_n;
      if (cfg_swap) begin
        out_en <= 1'b0;
        hit_q  <= 1'b0;
      end else if (strobe_rise) begin
        out_en <= armed;
        hit_q  <= local_hit & flag_en;
      end
    end
  end

  assign match_out_n = ~(out_en & (hit_q | ~match_in_n));
  assign owner       = out_en & hit_q & match_in_n;

endmodule

// File: rtl/chain_match_flag_chk.sv
module chain_match_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_n,
  input logic chain_en_n,
  input logic local_hit,
  input logic match_in_n,
  input logic flag_en,
  input logic cfg_swap,
  input logic match_out_n,
  input logic owner
);

  logic sq, arm_c, pass_c, off_c;
  wire rise_c = ~sq & strobe_n;
  wire fall_c = sq & ~strobe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq <= 1'b1; arm_c <= 1'b0; pass_c <= 1'b0; off_c <= 1'b1;
    end else begin
      sq <= strobe_n;
      if (fall_c) arm_c <= ~chain_en_n;
      if (cfg_swap) begin
        pass_c <= 1'b0; off_c <= 1'b1;
      end else if (rise_c) begin
        pass_c <= arm_c & ~flag_en;
        off_c  <= ~arm_c;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (match_out_n && !owner));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_c |-> (match_out_n == match_in_n));

  assert_chain_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_c |-> (match_out_n && !owner));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_c && !cfg_swap) |=> (!$stable(match_in_n) || ($stable(match_out_n) && $stable(owner))));

  assert_swap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_swap |=> (match_out_n && !owner));

  assert_owner_needs_idle_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owner |-> (match_in_n && !match_out_n));

endmodule

bind chain_match_flag chain_match_flag_chk u_chk (.*);

// File: tb/chain_match_flag_test.sv
`timescale 1ns/1ps
module chain_match_flag_test;

  logic clk = 1'b0;
  logic rst_n, strobe_n, chain_en_n, local_hit, match_in_n, flag_en, cfg_swap;
  logic match_out_n, owner;
  int checks = 0;
  int errors = 0;
  bit m_en, m_flag;

  always #5 clk = ~clk;

  chain_match_flag uut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_mo(input logic mi);
    return ~(m_en & (m_flag | ~mi));
  endfunction

  function automatic logic exp_own(input logic mi);
    return m_en & m_flag & mi;
  endfunction

  task automatic strobe_cycle(input logic ce, input logic fe, input logic hit, input logic mi);
    @(negedge clk);
    strobe_n = 1'b0; chain_en_n = ce;
    local_hit = ~hit; flag_en = ~fe;
    @(negedge clk);
    chain_en_n = ~ce;
    local_hit = hit; flag_en = fe;
    #1;
    check("R5 hold before rise", match_out_n, exp_mo(match_in_n));
    check("R5 owner hold", owner, exp_own(match_in_n));
    @(negedge clk);
    chain_en_n = ~ce;
    strobe_n = 1'b1;
    match_in_n = mi;
    @(negedge clk);
    m_en = ~ce; m_flag = fe & hit;
    if (ce) begin
      check("R4 disabled mo", match_out_n, 1'b1);
      check("R4 disabled owner", owner, 1'b0);
    end else if (!fe) begin
      check("R3 pass-through", match_out_n, mi);
    end
    check("R2 match_out", match_out_n, exp_mo(mi));
    check("R8 owner", owner, exp_own(mi));
    check("R6 late chain_en", match_out_n, exp_mo(mi));
    match_in_n = ~mi;
    #1;
    check("R2 ripple", match_out_n, exp_mo(~mi));
    check("R8 owner ripple", owner, exp_own(~mi));
    @(negedge clk);
    local_hit = ~hit; flag_en = ~fe;
    @(negedge clk);
    check("R5 ignored hit/flag", match_out_n, exp_mo(match_in_n));
    check("R5 ignored owner", owner, exp_own(match_in_n));
    chain_en_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; strobe_n = 1'b1; chain_en_n = 1'b1; local_hit = 1'b0;
    match_in_n = 1'b1; flag_en = 1'b0; cfg_swap = 1'b0;
    m_en = 1'b0; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mo", match_out_n, 1'b1);
    check("R1 reset owner", owner, 1'b0);
    match_in_n = 1'b0;
    #1;
    check("R1 reset ignores match_in", match_out_n, 1'b1);
    match_in_n = 1'b1;

    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 16; v++)
        strobe_cycle(v[3], v[2], v[1], v[0]);

    strobe_cycle(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    cfg_swap = 1'b1;
    @(negedge clk);
    cfg_swap = 1'b0;
    m_en = 1'b0; m_flag = 1'b0;
    check("R7 swap clears mo", match_out_n, 1'b1);
    check("R7 swap clears owner", owner, 1'b0);
    match_in_n = 1'b0;
    #1;
    check("R7 swap holds mo high", match_out_n, 1'b1);
    match_in_n = 1'b1;

    strobe_cycle(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    strobe_n = 1'b0; chain_en_n = 1'b0;
    @(negedge clk);
    chain_en_n = 1'b1;
    @(negedge clk);
    strobe_n = 1'b1; cfg_swap = 1'b1;
    @(negedge clk);
    cfg_swap = 1'b0;
    m_en = 1'b0; m_flag = 1'b0;
    check("R7 swap beats rise mo", match_out_n, 1'b1);
    check("R7 swap beats rise owner", owner, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule